// File: doc/BRIEF.md
# Transmit Byte-Pair FIFO

This block is the byte-wide transmit queue that sits between a UART's register interface and its serial shifter. Each write carries sixteen data bits and a pair-select input: with pair-select low only the low byte is queued, with it high both bytes are queued, low byte first. The shifter drains the queue one byte at a time over a valid/ready handshake.

The queue reports its fill level and a set of flags: full, nearly-full, a trigger flag against a programmable threshold, and one-cycle pulses for a rejected (overflowing) write, for reaching full and for being emptied. A two-bit write-size setting tells the queue how large the next write is expected to be, so nearly-full warns exactly when a write of that size would no longer fit. A write that does not fit is dropped as a whole; a two-byte write can therefore overflow while one slot is still free.

The write side has no back-pressure: a write strobe is always taken in the cycle it is presented, and the overflow pulse is its only refusal. On the read side `rd_valid` is high whenever at least one byte is held, a byte leaves when `rd_valid` and `rd_ready` are both high at a clock edge, and while `rd_valid` is high and `rd_ready` low, `rd_data` holds its value.

Top module: `txq_pairfifo`

## Requirements
- R1: After reset the fill level is 0, `rd_valid`, `full`, `nearly_full` and all three pulses are low.
- R2: A write with `wr_pair` low queues `wr_data[7:0]`; a write with `wr_pair` high queues `wr_data[7:0]` then `wr_data[15:8]`; bytes leave on `rd_data` in the order they were queued.
- R3: A write whose byte count (1 or 2) exceeds the free space (DEPTH minus the fill level before the edge) is discarded with no byte stored, and `ovf_pulse` is high for exactly the one cycle after that edge; with write-size two this means any write while full and any pair write while nearly-full.
- R4: `nearly_full` is high when the free space is below the write-size byte count, where write-size 01 counts 1 byte and 00, 10 and 11 count 2 bytes.
- R5: `full` is high exactly when the fill level equals DEPTH, and `full_evt` is high for one cycle after an edge that takes the level from below DEPTH to DEPTH.
- R6: `empty_evt` is high for one cycle after an edge at which a byte is popped and the level becomes 0.
- R7: `trig_hit` is high exactly when the fill level is greater than or equal to `trig_level`.
- R8: A push and a pop at the same edge are both carried out; the level changes by bytes pushed minus bytes popped, while overflow is judged on the level before the edge.
- R9: `rd_valid` is high exactly when the level is nonzero, a pop happens when `rd_valid` and `rd_ready` are both high, and `rd_data` is stable while `rd_valid` is high and `rd_ready` is low.
- R10: `fill_level` reports the number of bytes held, updated one cycle after the edge that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken every cycle it is high |
| wr_pair | input | 1 | High: write two bytes; low: write one byte |
| wr_data | input | 16 | Write data, low byte queued first |
| wsize | input | 2 | Expected write size for nearly-full: 01 one byte, others two |
| trig_level | input | LVLW | Trigger threshold on the fill level |
| rd_valid | output | 1 | A byte is available |
| rd_ready | input | 1 | Shifter takes the byte |
| rd_data | output | 8 | Oldest byte held |
| fill_level | output | LVLW | Bytes held |
| full | output | 1 | Level equals DEPTH |
| nearly_full | output | 1 | Free space below the write-size count |
| trig_hit | output | 1 | Level at or above the threshold |
| ovf_pulse | output | 1 | One-cycle pulse after a discarded write |
| full_evt | output | 1 | One-cycle pulse after reaching full |
| empty_evt | output | 1 | One-cycle pulse after the last byte leaves |

## Verification
The assertions watch on every cycle that the level never exceeds the depth, that a discarded write leaves the level moved only by a concurrent pop, that the full and empty pulses coincide with the matching level, that nearly-full follows the write-size rule and that a stalled head byte holds. Byte ordering of pair writes, the exact cycle of each pulse, the trigger comparison across every threshold and the interplay of simultaneous push and pop under every write-size setting show only in the bench's sweeps, which compare each cycle against an arithmetic queue model.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [1:0] {
    WS_DEFAULT = 2'b00,
    WS_ONE     = 2'b01,
    WS_TWO     = 2'b10,
    WS_TWO_ALT = 2'b11
  } wsize_e;

  // Bytes that the next write is expected to carry (00 counts as two).
  function automatic logic [1:0] need_bytes(input logic [1:0] ws);
    return (ws == WS_ONE) ? 2'd1 : 2'd2;
  endfunction

  // Bytes carried by a write with the given pair-select.
  function automatic logic [1:0] write_bytes(input logic pair);
    return pair ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int ADDRW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pair,
  input  logic [2*DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0]    mem [DEPTH];
  logic [ADDRW-1:0] wp, rp;
  logic [ADDRW-1:0] wp_next1;

  assign wp_next1 = wp + ADDRW'(1);

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wp] <= wdata[DW-1:0];
      if (pair) mem[wp_next1] <= wdata[2*DW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= pair ? wp + ADDRW'(2) : wp_next1;
      if (pop)  rp <= rp + ADDRW'(1);
    end
  end

  assign rdata = mem[rp];

endmodule

// File: rtl/txq_level.sv
module txq_level
  import txq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pair,
  input  logic            pop,
  input  logic [1:0]      wsize,
  input  logic [LVLW-1:0] trig_level,
  output logic [LVLW-1:0] level,
  output logic [LVLW-1:0] level_nxt,
  output logic [LVLW-1:0] free,
  output logic            full,
  output logic            nearly_full,
  output logic            trig_hit
);

  logic [1:0] added;

  assign added     = push ? write_bytes(pair) : 2'd0;
  assign level_nxt = level + LVLW'(added) - LVLW'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else        level <= level_nxt;
  end

  assign free        = LVLW'(DEPTH) - level;
  assign full        = (level == LVLW'(DEPTH));
  assign nearly_full = (free < LVLW'(need_bytes(wsize)));
  assign trig_hit    = (level >= trig_level);

  a_r10_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVLW'(DEPTH));

  // R4: a single free slot with a two-byte write size must warn
  a_r4_nf_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVLW'(DEPTH - 1)) && (wsize != 2'b01) |-> nearly_full);

  a_r5_full_implies_nf: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> nearly_full);

endmodule

// File: rtl/txq_events.sv
module txq_events #(
  parameter int DEPTH = 64,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLW-1:0] level,
  input  logic [LVLW-1:0] level_nxt,
  input  logic            pop,
  input  logic            reject,
  output logic            full_evt,
  output logic            empty_evt,
  output logic            ovf_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_evt  <= 1'b0;
      empty_evt <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      full_evt  <= (level_nxt == LVLW'(DEPTH)) && (level != LVLW'(DEPTH));
      empty_evt <= pop && (level_nxt == '0);
      ovf_pulse <= reject;
    end
  end

  a_r5_full_evt_level: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |-> (level == LVLW'(DEPTH)));

  a_r6_empty_evt_level: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |-> (level == '0));

  a_r5_full_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> !full_evt);

endmodule

// File: rtl/txq_pairfifo.sv
module txq_pairfifo
  import txq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_pair,
  input  logic [2*DW-1:0] wr_data,
  input  logic [1:0]      wsize,
  input  logic [LVLW-1:0] trig_level,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [DW-1:0]   rd_data,
  output logic [LVLW-1:0] fill_level,
  output logic            full,
  output logic            nearly_full,
  output logic            trig_hit,
  output logic            ovf_pulse,
  output logic            full_evt,
  output logic            empty_evt
);

  logic [LVLW-1:0] level, level_nxt, free;
  logic            reject, push, pop;

  assign reject   = wr_en && (LVLW'(write_bytes(wr_pair)) > free);
  assign push     = wr_en && !reject;
  assign rd_valid = (level != '0);
  assign pop      = rd_valid && rd_ready;

  txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pair  (wr_pair),
    .wdata (wr_data),
    .pop   (pop),
    .rdata (rd_data)
  );

  txq_level #(.DEPTH(DEPTH)) u_level (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .pair        (wr_pair),
    .pop         (pop),
    .wsize       (wsize),
    .trig_level  (trig_level),
    .level       (level),
    .level_nxt   (level_nxt),
    .free        (free),
    .full        (full),
    .nearly_full (nearly_full),
    .trig_hit    (trig_hit)
  );

  txq_events #(.DEPTH(DEPTH)) u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .level_nxt (level_nxt),
    .pop       (pop),
    .reject    (reject),
    .full_evt  (full_evt),
    .empty_evt (empty_evt),
    .ovf_pulse (ovf_pulse)
  );

  assign fill_level = level;

  a_r3_reject_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reject) |=> (level == $past(level) - LVLW'($past(pop))));

  a_r3_ovf_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(wr_en));

  a_r9_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: tb/txq_pairfifo_tb.sv
module txq_pairfifo_tb;

  localparam int D  = 8;
  localparam int LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_pair, rd_ready;
  logic [15:0]   wr_data;
  logic [1:0]    wsize;
  logic [LW-1:0] trig_level;
  logic          rd_valid, full, nearly_full, trig_hit, ovf_pulse, full_evt, empty_evt;
  logic [7:0]    rd_data;
  logic [LW-1:0] fill_level;

  int errs = 0, checks = 0;
  byte unsigned q[$];
  bit exp_ovf = 0, exp_fevt = 0, exp_eevt = 0;
  int bytectr = 0;

  always #4 clk = ~clk;

  txq_pairfifo #(.DW(8), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pair(wr_pair), .wr_data(wr_data),
    .wsize(wsize), .trig_level(trig_level), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .fill_level(fill_level), .full(full), .nearly_full(nearly_full),
    .trig_hit(trig_hit), .ovf_pulse(ovf_pulse), .full_evt(full_evt), .empty_evt(empty_evt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int n = q.size();
    int need = (wsize == 2'b01) ? 1 : 2;
    chk(fill_level == LW'(n), "R10 fill_level", fill_level, n);
    chk(rd_valid == (n != 0), "R9 rd_valid", rd_valid, n != 0);
    chk(full == (n == D), "R5 full", full, n == D);
    chk(nearly_full == ((D - n) < need), "R4 nearly_full", nearly_full, (D - n) < need);
    chk(trig_hit == (n >= int'(trig_level)), "R7 trig_hit", trig_hit, n >= int'(trig_level));
    chk(ovf_pulse == exp_ovf, "R3 ovf_pulse", ovf_pulse, exp_ovf);
    chk(full_evt == exp_fevt, "R5 full_evt", full_evt, exp_fevt);
    chk(empty_evt == exp_eevt, "R6 empty_evt", empty_evt, exp_eevt);
    if (n != 0) chk(rd_data == q[0], "R2 rd_data order", rd_data, q[0]);
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge, check after it.
  task automatic step(input bit en, input bit pair, input bit ready);
    int old_n, nb;
    bit pop, rej;
    @(negedge clk);
    wr_en    = en;
    wr_pair  = pair;
    wr_data  = {8'(bytectr + 1), 8'(bytectr)};
    rd_ready = ready;
    @(posedge clk);
    old_n = q.size();
    nb    = pair ? 2 : 1;
    pop   = ready && (old_n != 0);
    rej   = en && (nb > D - old_n);            // R3: judged before the edge (R8)
    if (pop) void'(q.pop_front());
    if (en && !rej) begin
      q.push_back(wr_data[7:0]);
      if (pair) q.push_back(wr_data[15:8]);
      bytectr += 2;
    end
    exp_ovf  = rej;
    exp_fevt = (q.size() == D) && (old_n != D);
    exp_eevt = pop && (q.size() == 0);
    #1;
    check_all();
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_pair = 0; wr_data = '0; rd_ready = 0;
    wsize = 2'b10; trig_level = LW'(1);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_all();
    @(negedge clk) rst_n = 1'b1;

    for (int ws = 0; ws < 4; ws++) begin
      for (int t = 0; t <= D; t++) begin
        @(negedge clk);
        wsize = 2'(ws);
        trig_level = LW'(t);
        // R2 fill with pairs, then R3 overflow on pairs and singles while full
        for (int i = 0; i < 6; i++) step(1, 1, 0);
        step(1, 0, 0);
        // R9 stall: head held
        step(0, 0, 0);
        // one slot free: pair rejected (R3), single accepted
        step(0, 0, 1);
        step(1, 1, 0);
        step(1, 0, 0);
        // R8 push and pop at same edge while full: rejected pair plus pop
        step(1, 1, 1);
        step(1, 0, 1);
        // drain (R6)
        for (int i = 0; i < D + 2; i++) step(0, 0, 1);
        // R8 mixed traffic
        for (int i = 0; i < 10; i++) step(1, (i % 3) != 0, 1);
        for (int i = 0; i < 4; i++) step(1, i[0], 0);
        for (int i = 0; i < 12; i++) step(i[1], 1, 1);
        for (int i = 0; i < D + 2; i++) step(0, 0, 1);
        // single-byte fill to full (R5) then drain
        for (int i = 0; i < D + 1; i++) step(1, 0, 0);
        for (int i = 0; i < D + 1; i++) step(0, 0, 1);
      end
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule